// File: doc/BRIEF.md
# Hardware Task Dependency Pool

This block sits between a master processor that issues tasks in program order and a group of worker cores that run them. Every task arrives as a descriptor: a function identifier plus up to `MAX_PARAMS` parameters. Each parameter describes a two-dimensional memory region (start address, bytes per row, row count, distance between rows) and whether the task reads it, writes it or does both. The pool stores each accepted task in a slot of a fixed-size table. It compares the regions the new task reads against the regions that every unfinished older task writes. Any older task with an overlapping region becomes a predecessor of the new one.

A slot keeps a count of its unfinished predecessors and a bit-vector of the slots that wait on it. A slot whose count is zero is moved into a ready FIFO, one slot per cycle. Workers pop that FIFO and receive the slot index and the function identifier. When a worker finishes, it reports the slot index. The pool then decrements the count of every dependent and frees the slot. The descriptor intake can take a new task on every cycle as long as a slot is free.

Top module: `tdp_pool`

## Requirements
- R1: Once reset has been released and synchronised, `sub_ready` is 1 and `rdy_valid` is 0.
- R2: The access code of a parameter is bit 0 = reads and bit 1 = writes, so 01 means input, 10 means output and 11 means inout. Parameters at a position equal to or above `sub_nparams` are ignored.
- R3: A task with no overlapping predecessor reaches the ready output and carries its own function identifier.
- R4: A task is held back from the ready output while any older, unfinished task writes a region that overlaps a region the new task reads.
- R5: Two regions that are only read, or that are only written, never create a dependency. Regions that do not overlap never create a dependency.
- R6: An inout parameter acts both as a read, which creates a dependency on older writers, and as a write, which creates a dependency for later readers.
- R7: The ready output follows FIFO order. Tasks that become ready in different cycles leave in that order. Tasks submitted back to back with no predecessors leave in submission order.
- R8: The table holds `NUM_ENT` (default 16) tasks. When every slot is in use, `sub_ready` is 0 and no descriptor is accepted until a completion frees a slot.
- R9: A completion in the same cycle as a submission takes effect first. The new task records no dependency on the task that has just finished.
- R10: A row-by-column wavefront, in which each task reads its upper and left neighbours and writes its own tile, is released without any task running before both of its neighbours have finished.
- R11: A task with several predecessors is released only after the last of them completes.
- R12: A region covers the addresses from its base up to base + (rows-1)*stride + row length, with the upper bound exclusive. A region that starts exactly at the end of another does not overlap it. A region that touches the last row of a multi-row region does overlap it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sub_valid | input | 1 | Descriptor offered |
| sub_ready | output | 1 | A free slot exists; descriptor accepted when both are high |
| sub_func | input | FW | Function identifier |
| sub_nparams | input | PCW | Number of parameters in use |
| sub_acc | input | MAX_PARAMS*2 | Access code per parameter |
| sub_base | input | MAX_PARAMS*AW | Region base address per parameter |
| sub_xlen | input | MAX_PARAMS*LW | Bytes per row per parameter |
| sub_ylen | input | MAX_PARAMS*LW | Row count per parameter |
| sub_stride | input | MAX_PARAMS*AW | Row distance per parameter |
| rdy_valid | output | 1 | A ready task is offered |
| rdy_ready | input | 1 | Worker takes the offered task |
| rdy_idx | output | IW | Slot index of the offered task |
| rdy_func | output | FW | Function identifier of the offered task |
| done_valid | input | 1 | Completion report |
| done_idx | input | IW | Slot index of the finished task |

## Verification
The assertions assume that a worker reports completion only for a slot it has popped and not yet reported. They also assume that every region has at least one byte per row and does not wrap the address space. The bench meets these assumptions by completing only indices it has received from the ready output, each exactly once. All of its regions lie in low, widely separated address windows. It uses directed scenarios that drive dependent chains, a completion that arrives together with a submission, a full table and a three-by-three wavefront.

// File: rtl/tdp_pkg.sv
package tdp_pkg;
  typedef enum logic [1:0] {
    ST_FREE   = 2'd0,
    ST_WAIT   = 2'd1,
    ST_QUEUED = 2'd2,
    ST_RUN    = 2'd3
  } slot_state_e;

  localparam int ACC_RD_BIT = 0;
  localparam int ACC_WR_BIT = 1;
endpackage

// File: rtl/tdp_span.sv
module tdp_span #(
  parameter int AW = 32,
  parameter int LW = 12,
  localparam int SW = AW + LW + 1
) (
  input  logic [AW-1:0] base,
  input  logic [LW-1:0] xlen,
  input  logic [LW-1:0] ylen,
  input  logic [AW-1:0] stride,
  output logic [SW-1:0] lo,
  output logic [SW-1:0] hi
);
  logic [LW-1:0] rows_m1;
  logic [SW-1:0] last_row;

  always_comb begin
    rows_m1  = (ylen == '0) ? '0 : ylen - LW'(1);
    last_row = SW'(rows_m1) * SW'(stride);
    lo       = SW'(base);
    hi       = SW'(base) + last_row + SW'(xlen);
  end
endmodule

// File: rtl/tdp_fifo.sv
module tdp_fifo #(
  parameter int DEPTH = 16,
  parameter int DW    = 4,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic          out_valid,
  output logic [DW-1:0] out_data
);
  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wr_ptr, wr_ptr_d, rd_ptr, rd_ptr_d;
  logic [CW-1:0] fill, fill_d;
  logic          do_pop;

  assign out_valid = (fill != '0);
  assign out_data  = mem[rd_ptr];
  assign do_pop    = pop && out_valid;

  always_comb begin
    wr_ptr_d = wr_ptr;
    rd_ptr_d = rd_ptr;
    fill_d   = fill;
    if (push) wr_ptr_d = (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + PW'(1);
    if (do_pop) rd_ptr_d = (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + PW'(1);
    if (push && !do_pop) fill_d = fill + CW'(1);
    else if (!push && do_pop) fill_d = fill - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      fill   <= '0;
    end else begin
      wr_ptr <= wr_ptr_d;
      rd_ptr <= rd_ptr_d;
      fill   <= fill_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_data;
  end

  // R7: a slot is queued at most once, so the FIFO can never be pushed while full
  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (fill < CW'(DEPTH)) || do_pop);
endmodule

// File: rtl/tdp_pool.sv
module tdp_pool
  import tdp_pkg::*;
#(
  parameter int NUM_ENT    = 16,
  parameter int MAX_PARAMS = 3,
  parameter int AW         = 32,
  parameter int LW         = 12,
  parameter int FW         = 8,
  localparam int IW  = $clog2(NUM_ENT),
  localparam int PCW = $clog2(MAX_PARAMS + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     sub_valid,
  output logic                     sub_ready,
  input  logic [FW-1:0]            sub_func,
  input  logic [PCW-1:0]           sub_nparams,
  input  logic [MAX_PARAMS*2-1:0]  sub_acc,
  input  logic [MAX_PARAMS*AW-1:0] sub_base,
  input  logic [MAX_PARAMS*LW-1:0] sub_xlen,
  input  logic [MAX_PARAMS*LW-1:0] sub_ylen,
  input  logic [MAX_PARAMS*AW-1:0] sub_stride,
  output logic                     rdy_valid,
  input  logic                     rdy_ready,
  output logic [IW-1:0]            rdy_idx,
  output logic [FW-1:0]            rdy_func,
  input  logic                     done_valid,
  input  logic [IW-1:0]            done_idx
);
  localparam int SW = AW + LW + 1;
  localparam int CW = $clog2(NUM_ENT + 1);

  // reset: asserted asynchronously, released on a clock edge
  logic rst_q1, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_q1     <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_q1     <= 1'b1;
      rst_sync_n <= rst_q1;
    end
  end

  // slot table
  slot_state_e          st   [NUM_ENT];
  slot_state_e          st_d [NUM_ENT];
  logic [CW-1:0]        cnt  [NUM_ENT];
  logic [CW-1:0]        cnt_d[NUM_ENT];
  logic [NUM_ENT-1:0]   deps  [NUM_ENT];
  logic [NUM_ENT-1:0]   deps_d[NUM_ENT];
  logic [FW-1:0]        ent_func[NUM_ENT];
  logic [MAX_PARAMS-1:0] ent_wr [NUM_ENT];
  logic [SW-1:0]        ent_lo [NUM_ENT][MAX_PARAMS];
  logic [SW-1:0]        ent_hi [NUM_ENT][MAX_PARAMS];

  // incoming descriptor regions
  logic [SW-1:0]         new_lo [MAX_PARAMS];
  logic [SW-1:0]         new_hi [MAX_PARAMS];
  logic [MAX_PARAMS-1:0] new_rd, new_wr;

  for (genvar p = 0; p < MAX_PARAMS; p++) begin : g_span
    tdp_span #(.AW(AW), .LW(LW)) u_span (
      .base  (sub_base  [p*AW +: AW]),
      .xlen  (sub_xlen  [p*LW +: LW]),
      .ylen  (sub_ylen  [p*LW +: LW]),
      .stride(sub_stride[p*AW +: AW]),
      .lo    (new_lo[p]),
      .hi    (new_hi[p])
    );
    assign new_rd[p] = (PCW'(p) < sub_nparams) && sub_acc[p*2 + ACC_RD_BIT];
    assign new_wr[p] = (PCW'(p) < sub_nparams) && sub_acc[p*2 + ACC_WR_BIT];
  end

  logic [NUM_ENT-1:0] conflict, free_vec, zero_wait;
  logic [IW-1:0]      alloc_idx, launch_idx, fifo_idx;
  logic               alloc_fire, launch_any, pop_fire, done_fire, fifo_valid;

  always_comb begin
    conflict  = '0;
    free_vec  = '0;
    zero_wait = '0;
    for (int e = 0; e < NUM_ENT; e++) begin
      free_vec[e]  = (st[e] == ST_FREE);
      zero_wait[e] = (st[e] == ST_WAIT) && (cnt[e] == '0);
      if (st[e] != ST_FREE && !(done_fire && done_idx == IW'(e))) begin
        for (int q = 0; q < MAX_PARAMS; q++) begin
          for (int p = 0; p < MAX_PARAMS; p++) begin
            if (ent_wr[e][q] && new_rd[p] &&
                ent_lo[e][q] < new_hi[p] && new_lo[p] < ent_hi[e][q])
              conflict[e] = 1'b1;
          end
        end
      end
    end
    alloc_idx  = '0;
    launch_idx = '0;
    for (int e = NUM_ENT - 1; e >= 0; e--) begin
      if (free_vec[e])  alloc_idx  = IW'(e);
      if (zero_wait[e]) launch_idx = IW'(e);
    end
  end

  assign sub_ready  = rst_sync_n && (free_vec != '0);
  assign alloc_fire = sub_valid && sub_ready;
  assign launch_any = (zero_wait != '0);
  assign done_fire  = done_valid;
  assign rdy_valid  = fifo_valid;
  assign rdy_idx    = fifo_idx;
  assign rdy_func   = ent_func[fifo_idx];
  assign pop_fire   = fifo_valid && rdy_ready;

  tdp_fifo #(.DEPTH(NUM_ENT), .DW(IW)) u_ready (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .push     (launch_any),
    .push_data(launch_idx),
    .pop      (rdy_ready),
    .out_valid(fifo_valid),
    .out_data (fifo_idx)
  );

  // next state: completion first, then launch, pop and allocation
  always_comb begin
    for (int e = 0; e < NUM_ENT; e++) begin
      st_d[e]   = st[e];
      cnt_d[e]  = cnt[e];
      deps_d[e] = deps[e];
    end
    if (done_fire) begin
      st_d[done_idx]   = ST_FREE;
      deps_d[done_idx] = '0;
      for (int e = 0; e < NUM_ENT; e++)
        if (deps[done_idx][e]) cnt_d[e] = cnt[e] - CW'(1);
    end
    if (launch_any) st_d[launch_idx] = ST_QUEUED;
    if (pop_fire)   st_d[fifo_idx]   = ST_RUN;
    if (alloc_fire) begin
      st_d[alloc_idx]   = ST_WAIT;
      cnt_d[alloc_idx]  = CW'($countones(conflict));
      deps_d[alloc_idx] = '0;
      for (int e = 0; e < NUM_ENT; e++)
        if (conflict[e]) deps_d[e][alloc_idx] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      for (int e = 0; e < NUM_ENT; e++) begin
        st[e]   <= ST_FREE;
        cnt[e]  <= '0;
        deps[e] <= '0;
      end
    end else begin
      for (int e = 0; e < NUM_ENT; e++) begin
        st[e]   <= st_d[e];
        cnt[e]  <= cnt_d[e];
        deps[e] <= deps_d[e];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (alloc_fire) begin
      ent_func[alloc_idx] <= sub_func;
      ent_wr[alloc_idx]   <= new_wr;
      for (int p = 0; p < MAX_PARAMS; p++) begin
        ent_lo[alloc_idx][p] <= new_lo[p];
        ent_hi[alloc_idx][p] <= new_hi[p];
      end
    end
  end

  // R4: only a task handed to a worker may be reported finished
  p_done_running_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    done_valid |-> st[done_idx] == ST_RUN);

  // R7: the head of the ready FIFO is always a queued slot
  p_head_queued_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rdy_valid |-> st[rdy_idx] == ST_QUEUED);

  // R9: a reported slot is free on the next cycle
  p_freed_after_done_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    done_valid |=> st[$past(done_idx)] == ST_FREE);

  // R11: a dependent never sees its counter decremented below zero
  for (genvar e = 0; e < NUM_ENT; e++) begin : g_chk
    p_no_underflow_r11: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (done_valid && deps[done_idx][e]) |-> cnt[e] != '0);
  end
endmodule

// File: tb/tdp_pool_test.sv
module tdp_pool_test;
  localparam int NE = 16, MP = 3, AW = 32, LW = 12, FW = 8, IW = 4, PCW = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sub_valid = 1'b0, rdy_ready = 1'b0, done_valid = 1'b0;
  logic sub_ready, rdy_valid;
  logic [FW-1:0] sub_func = '0, rdy_func;
  logic [PCW-1:0] sub_nparams = '0;
  logic [MP*2-1:0] sub_acc = '0;
  logic [MP*AW-1:0] sub_base = '0, sub_stride = '0;
  logic [MP*LW-1:0] sub_xlen = '0, sub_ylen = '0;
  logic [IW-1:0] rdy_idx, done_idx = '0;

  always #2 clk = ~clk;

  tdp_pool uut (
    .clk(clk), .rst_n(rst_n), .sub_valid(sub_valid), .sub_ready(sub_ready),
    .sub_func(sub_func), .sub_nparams(sub_nparams), .sub_acc(sub_acc),
    .sub_base(sub_base), .sub_xlen(sub_xlen), .sub_ylen(sub_ylen),
    .sub_stride(sub_stride), .rdy_valid(rdy_valid), .rdy_ready(rdy_ready),
    .rdy_idx(rdy_idx), .rdy_func(rdy_func), .done_valid(done_valid),
    .done_idx(done_idx)
  );

  int checks = 0, fails = 0, cyc = 0;
  logic [IW-1:0] got_idx;
  logic [FW-1:0] got_func;
  logic got_ok;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic setp(input int p, input logic [1:0] acc, input logic [31:0] base,
                      input int x, input int y, input logic [31:0] stride);
    sub_acc[p*2 +: 2]     = acc;
    sub_base[p*AW +: AW]  = base;
    sub_xlen[p*LW +: LW]  = LW'(x);
    sub_ylen[p*LW +: LW]  = LW'(y);
    sub_stride[p*AW +: AW] = stride;
  endtask

  task automatic clrp();
    sub_acc = '0; sub_base = '0; sub_xlen = '0; sub_ylen = '0; sub_stride = '0;
  endtask

  task automatic submit(input int f, input int np);
    @(negedge clk);
    sub_func = FW'(f); sub_nparams = PCW'(np); sub_valid = 1'b1;
    while (!sub_ready) @(negedge clk);
    @(negedge clk);
    sub_valid = 1'b0;
    clrp();
  endtask

  task automatic pop();
    int t = 0;
    @(negedge clk);
    while (!rdy_valid && t < 60) begin @(negedge clk); t++; end
    got_ok = rdy_valid; got_idx = rdy_idx; got_func = rdy_func;
    if (rdy_valid) begin
      rdy_ready = 1'b1;
      @(negedge clk);
      rdy_ready = 1'b0;
    end
  endtask

  task automatic complete(input logic [IW-1:0] idx);
    @(negedge clk);
    done_valid = 1'b1; done_idx = idx;
    @(negedge clk);
    done_valid = 1'b0;
  endtask

  task automatic expect_pop(input int f, input string req);
    pop();
    check(got_ok && got_func == FW'(f), req, got_ok ? int'(got_func) : -1, f);
  endtask

  task automatic expect_idle(input int n, input string req);
    bit seen = 1'b0;
    for (int k = 0; k < n; k++) begin @(negedge clk); if (rdy_valid) seen = 1'b1; end
    check(!seen, req, seen, 0);
  endtask

  task automatic t_reset();
    repeat (4) @(negedge clk);
    check(sub_ready === 1'b1, "R1 sub_ready", sub_ready, 1);
    check(rdy_valid === 1'b0, "R1 rdy_valid", rdy_valid, 0);
  endtask

  task automatic t_chain();
    logic [IW-1:0] a;
    setp(0, 2'b10, 32'h100, 16, 1, 0); submit(1, 1);
    setp(0, 2'b01, 32'h108, 4, 1, 0);  submit(2, 1);
    expect_pop(1, "R3 independent task");
    a = got_idx;
    expect_idle(6, "R4 reader held behind writer");
    complete(a);
    expect_pop(2, "R4 released after writer");
    complete(got_idx);
  endtask

  task automatic t_disjoint();
    logic [IW-1:0] i1, i2, i3;
    setp(0, 2'b10, 32'h1000, 16, 1, 0); submit(3, 1);
    setp(0, 2'b01, 32'h1010, 16, 1, 0); submit(4, 1);          // R12 touching
    setp(0, 2'b01, 32'h3000, 8, 1, 0);
    setp(1, 2'b01, 32'h1000, 8, 1, 0);  submit(5, 1);          // R2 masked param
    expect_pop(3, "R7 order first");  i1 = got_idx;
    expect_pop(4, "R12 touching regions independent"); i2 = got_idx;
    expect_pop(5, "R2 masked parameter ignored"); i3 = got_idx;
    setp(0, 2'b01, 32'h3000, 8, 1, 0); submit(6, 1);           // read-read
    setp(0, 2'b10, 32'h1000, 8, 1, 0); submit(7, 1);           // write-write
    expect_pop(6, "R5 read-read no dependency");
    complete(got_idx);
    expect_pop(7, "R5 write-write no dependency");
    complete(got_idx); complete(i1); complete(i2); complete(i3);
  endtask

  task automatic t_2d();
    logic [IW-1:0] a;
    setp(0, 2'b10, 32'h4000, 4, 4, 32'h100); submit(8, 1);
    setp(0, 2'b01, 32'h4304, 4, 1, 0);       submit(9, 1);
    setp(0, 2'b01, 32'h4300, 4, 1, 0);       submit(10, 1);
    expect_pop(8, "R12 2D writer");   a = got_idx;
    expect_pop(9, "R12 past last row independent");
    complete(got_idx);
    expect_idle(5, "R12 last row overlaps");
    complete(a);
    expect_pop(10, "R12 released");
    complete(got_idx);
  endtask

  task automatic t_inout();
    logic [IW-1:0] a, b;
    setp(0, 2'b11, 32'h5000, 16, 1, 0); submit(11, 1);
    setp(0, 2'b11, 32'h5000, 16, 1, 0); submit(12, 1);
    setp(0, 2'b01, 32'h5004, 4, 1, 0);  submit(13, 1);
    expect_pop(11, "R6 first inout"); a = got_idx;
    expect_idle(5, "R6 inout waits on inout");
    complete(a);
    expect_pop(12, "R6 second inout"); b = got_idx;
    expect_idle(5, "R6 reader waits on inout writer");
    complete(b);
    expect_pop(13, "R6 reader released");
    complete(got_idx);
  endtask

  task automatic t_full();
    logic [IW-1:0] ids [NE];
    for (int k = 0; k < NE; k++) begin
      setp(0, 2'b10, 32'h10000 + 32'(k) * 32'h40, 8, 1, 0); submit(32 + k, 1);
    end
    @(negedge clk);
    check(sub_ready === 1'b0, "R8 full table back-pressure", sub_ready, 0);
    for (int k = 0; k < NE; k++) begin
      expect_pop(32 + k, "R7 FIFO order of full table");
      ids[k] = got_idx;
    end
    check(sub_ready === 1'b0, "R8 still full while running", sub_ready, 0);
    for (int k = 0; k < NE; k++) complete(ids[k]);
    @(negedge clk);
    check(sub_ready === 1'b1, "R8 slots freed", sub_ready, 1);
  endtask

  task automatic t_same_cycle();
    setp(0, 2'b10, 32'h7000, 16, 1, 0); submit(20, 1);
    expect_pop(20, "R9 writer");
    @(negedge clk);
    check(sub_ready === 1'b1, "R9 slot free", sub_ready, 1);
    setp(0, 2'b01, 32'h7000, 16, 1, 0);
    sub_func = 8'd21; sub_nparams = 2'd1; sub_valid = 1'b1;
    done_valid = 1'b1; done_idx = got_idx;
    @(negedge clk);
    sub_valid = 1'b0; done_valid = 1'b0; clrp();
    expect_pop(21, "R9 completion applied before submission");
    complete(got_idx);
  endtask

  task automatic t_multi();
    logic [IW-1:0] a, b;
    setp(0, 2'b10, 32'h8000, 16, 1, 0); submit(22, 1);
    setp(0, 2'b10, 32'h8100, 16, 1, 0); submit(23, 1);
    setp(0, 2'b01, 32'h8000, 4, 1, 0);
    setp(1, 2'b01, 32'h8100, 4, 1, 0);  submit(24, 2);
    expect_pop(22, "R11 pred A"); a = got_idx;
    expect_pop(23, "R11 pred B"); b = got_idx;
    complete(a);
    expect_idle(5, "R11 still one predecessor");
    complete(b);
    expect_pop(24, "R11 released after last");
    complete(got_idx);
  endtask

  task automatic t_wave();
    bit done_m [3][3];
    bit order_ok = 1'b1;
    int cnt = 0;
    for (int i = 0; i < 3; i++)
      for (int j = 0; j < 3; j++) begin
        int np = 1;
        done_m[i][j] = 1'b0;
        setp(0, 2'b11, 32'h9000 + 32'((i * 3 + j) * 16), 16, 1, 0);
        if (i > 0) begin setp(np, 2'b01, 32'h9000 + 32'(((i-1) * 3 + j) * 16), 16, 1, 0); np++; end
        if (j > 0) begin setp(np, 2'b01, 32'h9000 + 32'((i * 3 + j - 1) * 16), 16, 1, 0); np++; end
        submit(64 + i * 3 + j, np);
      end
    expect_pop(64, "R10 corner first");
    expect_idle(5, "R10 nothing else before corner finishes");
    done_m[0][0] = 1'b1; complete(got_idx); cnt++;
    for (int k = 1; k < 9; k++) begin
      pop();
      if (got_ok) begin
        int t = int'(got_func) - 64;
        int i = t / 3, j = t % 3;
        if ((i > 0 && !done_m[i-1][j]) || (j > 0 && !done_m[i][j-1])) order_ok = 1'b0;
        done_m[i][j] = 1'b1; cnt++;
        complete(got_idx);
      end
    end
    check(order_ok, "R10 neighbours finished first", order_ok, 1);
    check(cnt == 9, "R10 all tiles released", cnt, 9);
  endtask

  initial begin
    forever begin
      @(posedge clk); cyc++;
      if (cyc > 100000) begin
        fails++; checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_chain();
    t_disjoint();
    t_2d();
    t_inout();
    t_full();
    t_same_cycle();
    t_multi();
    t_wave();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule